// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of a read or write burst inside an SDRAM device or its controller. A read or write command delivers an address word. Its low eight bits are the start column, and one upper bit is the auto-precharge request, which is not part of the column. From the cycle after the command, the block presents one column per clock. It keeps presenting columns until the burst length chosen by the configuration inputs runs out, or until a terminate command or a new command stops it.

Two orderings are available. Sequential order counts the low bits of the column upward and wraps them inside the burst window. Interleaved order XORs the low bits of the start column with the beat index. A full-page length exists only for sequential order. It walks through all 256 columns, wraps from 255 to 0, and never ends by itself. The final beat of a finite burst is flagged, and the auto-precharge request travels out alongside that flag. Burst length and order are captured when the command is accepted.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, beatValid, beatLast and beatAutoPre are all low.
- R2: When cmdStart is high at a clock edge, the next cycle shows beatValid high and beatCol equal to cmdAddr[7:0]. cmdAddr[9:8] never affect the column. While the burst runs, one beat is presented per cycle.
- R3: In sequential order (cfgInterleave low), cfgLenCode 0, 1, 2 and 3 select burst lengths BL of 1, 2, 4 and 8. Beat k keeps the start column's bits above log2(BL), and its low log2(BL) bits equal (start + k) mod BL.
- R4: In interleaved order (cfgInterleave high), beat k is the start column with its low log2(BL) bits XORed with k. The same length codes apply as in R3.
- R5: In sequential order, cfgLenCode 7 selects full page: beat k is (start + k) mod 256. beatLast is never raised, and beats continue until a terminate or a new command.
- R6: cfgLenCode 7 with interleaved order behaves as a burst of 8. Codes 4, 5 and 6 behave as a burst of 1.
- R7: beatLast is high on the final beat of a finite burst and on no other beat. On the cycle after that beat, beatValid is low unless a new command was given.
- R8: beatAutoPre equals cmdAddr[10] as sampled with the command. It is high only together with beatLast.
- R9: When cmdStop is high at an edge without cmdStart, beatValid is low from the next cycle, and the ended burst raises no beatLast.
- R10: cmdStart during a running burst restarts it: the next cycle shows beat 0 of the new column under the new configuration. cmdStart takes priority over cmdStop in the same cycle.
- R11: Changes of cfgLenCode and cfgInterleave while a burst runs do not affect that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgLenCode | input | 3 | Burst length code (0..3 = 1,2,4,8; 7 = full page; 4..6 = one beat) |
| cfgInterleave | input | 1 | 1 selects interleaved order, 0 sequential |
| cmdStart | input | 1 | Read or write command strobe |
| cmdStop | input | 1 | Burst terminate strobe |
| cmdAddr | input | 11 | Command address: [7:0] column, [10] auto-precharge |
| beatValid | output | 1 | A burst beat is presented this cycle |
| beatCol | output | 8 | Column address of the current beat |
| beatLast | output | 1 | Current beat is the last of a finite burst |
| beatAutoPre | output | 1 | Auto-precharge request, shown with the last beat |

## Verification
The assertions treat cmdStart and cmdStop as single-cycle strobes driven cleanly between edges. They also assume the configuration inputs hold a defined value whenever a command is accepted. The bench drives every input on the falling edge, so each command and terminate lands on exactly one rising edge. The bench sweeps every start column under every length code in both orders, and it deliberately scrambles the configuration inputs and address bits 9:8 in the middle of bursts. That stimulus still keeps the configuration defined at each command edge.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new start column and configuration
    logic step;   // advance to the next beat
  } colgen_strobe_t;
endpackage

// File: rtl/colgen_datapath.sv
module colgen_datapath
  import colgen_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int ADDR_W = 11,
  parameter int AP_BIT = 10,
  parameter int LEN_W = 3,
  parameter int MAX_FIXED_CODE = 3,
  parameter int FULL_CODE = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  colgen_strobe_t    strb,
  input  logic [LEN_W-1:0]  cfgLenCode,
  input  logic              cfgInterleave,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic [COL_W-1:0]  beatCol,
  output logic              atEnd,
  output logic              apFlag
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);
  localparam logic [COL_W-1:0] ILV_FULL_MASK = (ONE << MAX_FIXED_CODE) - ONE;

  logic [COL_W-1:0] startCol;
  logic [COL_W-1:0] idx;
  logic [COL_W-1:0] mask;
  logic             interMode;
  logic             fullMode;
  logic [COL_W-1:0] newMask;
  logic             newFull;
  logic [COL_W-1:0] seqSum;
  logic [COL_W-1:0] seqCol;
  logic [COL_W-1:0] ilvCol;

  // Window mask for the requested length (R3, R4, R5, R6)
  always_comb begin
    newFull = 1'b0;
    if (int'(cfgLenCode) <= MAX_FIXED_CODE) begin
      newMask = (ONE << cfgLenCode) - ONE;
    end else if (int'(cfgLenCode) == FULL_CODE) begin
      if (cfgInterleave) begin
        newMask = ILV_FULL_MASK;
      end else begin
        newMask = '1;
        newFull = 1'b1;
      end
    end else begin
      newMask = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startCol  <= '0;
      idx       <= '0;
      mask      <= '0;
      interMode <= 1'b0;
      fullMode  <= 1'b0;
      apFlag    <= 1'b0;
    end else if (strb.load) begin
      startCol  <= cmdAddr[COL_W-1:0];
      idx       <= '0;
      mask      <= newMask;
      interMode <= cfgInterleave;
      fullMode  <= newFull;
      apFlag    <= cmdAddr[AP_BIT];
    end else if (strb.step) begin
      idx <= idx + ONE;
    end
  end

  // Sequential: low bits count and wrap inside the window
  assign seqSum = startCol + idx;
  assign seqCol = (startCol & ~mask) | (seqSum & mask);

  // Interleaved: per-bit XOR inside the window
  for (genvar i = 0; i < COL_W; i++) begin : g_ilv
    assign ilvCol[i] = mask[i] ? (startCol[i] ^ idx[i]) : startCol[i];
  end

  assign beatCol = interMode ? ilvCol : seqCol;
  assign atEnd   = !fullMode && (idx == mask);

  // R2: a load presents the commanded column on the next cycle
  assert_load_col_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (beatCol == $past(cmdAddr[COL_W-1:0])));

  // R3: a sequential step keeps the bits above the window
  assert_seq_upper_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !interMode) |=> ((beatCol & ~mask) == $past(beatCol & ~mask)));

  // R4: an interleaved step changes only bits inside the window
  assert_ilv_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && interMode) |=> (((beatCol ^ $past(beatCol)) & ~mask) == '0));
endmodule

// File: rtl/colgen_control.sv
module colgen_control
  import colgen_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           cmdStart,
  input  logic           cmdStop,
  input  logic           atEnd,
  output colgen_strobe_t strb,
  output logic           beatValid,
  output logic           beatLast
);
  logic active;

  // Start beats stop; stop beats natural end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                active <= 1'b0;
    else if (cmdStart)        active <= 1'b1;
    else if (cmdStop)         active <= 1'b0;
    else if (active && atEnd) active <= 1'b0;
  end

  always_comb begin
    strb.load = cmdStart;
    strb.step = active && !atEnd && !cmdStart && !cmdStop;
  end

  assign beatValid = active;
  assign beatLast  = active && atEnd;

  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStop && !cmdStart) |=> !beatValid);

  assert_last_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    beatLast |-> beatValid);

  assert_after_last_R7: assert property (@(posedge clk) disable iff (!rstN)
    (beatLast && !cmdStart) |=> !beatValid);

  assert_restart_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> beatValid);

  assert_run_on_R2: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !beatLast && !cmdStart && !cmdStop) |=> beatValid);
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int ADDR_W = 11,
  parameter int AP_BIT = 10,
  parameter int LEN_W = 3,
  parameter int MAX_FIXED_CODE = 3,
  parameter int FULL_CODE = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LEN_W-1:0]  cfgLenCode,
  input  logic              cfgInterleave,
  input  logic              cmdStart,
  input  logic              cmdStop,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              beatValid,
  output logic [COL_W-1:0]  beatCol,
  output logic              beatLast,
  output logic              beatAutoPre
);
  colgen_strobe_t strb;
  logic atEnd;
  logic apFlag;

  colgen_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdStart  (cmdStart),
    .cmdStop   (cmdStop),
    .atEnd     (atEnd),
    .strb      (strb),
    .beatValid (beatValid),
    .beatLast  (beatLast)
  );

  colgen_datapath #(
    .COL_W          (COL_W),
    .ADDR_W         (ADDR_W),
    .AP_BIT         (AP_BIT),
    .LEN_W          (LEN_W),
    .MAX_FIXED_CODE (MAX_FIXED_CODE),
    .FULL_CODE      (FULL_CODE)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .cfgLenCode    (cfgLenCode),
    .cfgInterleave (cfgInterleave),
    .cmdAddr       (cmdAddr),
    .beatCol       (beatCol),
    .atEnd         (atEnd),
    .apFlag        (apFlag)
  );

  assign beatAutoPre = beatLast && apFlag;

  assert_ap_last_R8: assert property (@(posedge clk) disable iff (!rstN)
    beatAutoPre |-> beatLast);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> !beatValid);
endmodule

// File: tb/sdram_burst_colgen_bench.sv
module sdram_burst_colgen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cfgLenCode = '0;
  logic        cfgInterleave = 1'b0;
  logic        cmdStart = 1'b0;
  logic        cmdStop = 1'b0;
  logic [10:0] cmdAddr = '0;
  logic        beatValid;
  logic [7:0]  beatCol;
  logic        beatLast;
  logic        beatAutoPre;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cycles <= cycles + 1;

  sdram_burst_colgen u_sdram_burst_colgen (
    .clk(clk), .rstN(rstN), .cfgLenCode(cfgLenCode), .cfgInterleave(cfgInterleave),
    .cmdStart(cmdStart), .cmdStop(cmdStop), .cmdAddr(cmdAddr),
    .beatValid(beatValid), .beatCol(beatCol), .beatLast(beatLast), .beatAutoPre(beatAutoPre)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int burstLen(input int code, input bit ilv);
    if (code <= 3) return 1 << code;
    if (code == 7) return ilv ? 8 : 256;
    return 1;
  endfunction

  function automatic int expCol(input int s, input int k, input int bl, input bit ilv);
    int m;
    m = bl - 1;
    if (ilv) return (s & ~m & 255) | ((s ^ k) & m);
    return (s & ~m & 255) | ((s + k) & m);
  endfunction

  // Issue a command at a falling edge; inputs clear at the next one
  task automatic issue(input int s, input int code, input bit ilv, input bit ap, input int junk);
    cmdAddr = {ap, 2'(junk), 8'(s)};
    cfgLenCode = 3'(code);
    cfgInterleave = ilv;
    cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    cfgLenCode = 3'(code + 3);   // R11: scrambled during the burst
    cfgInterleave = ~ilv;
    cmdAddr = 11'h7ff;
  endtask

  // Check beats 0..n-1 of a burst; returns at the sample point after beat n-1
  task automatic checkBeats(input string req, input int s, input int code, input bit ilv,
                            input bit ap, input int n);
    int bl;
    bit full;
    bl = burstLen(code, ilv);
    full = (code == 7) && !ilv;
    for (int k = 0; k < n; k++) begin
      bit lastExp;
      lastExp = !full && (k == bl - 1);
      chk({req, " valid"}, int'(beatValid), 1);
      chk({req, " col"}, int'(beatCol), expCol(s, k, bl, ilv));
      chk("R7 last", int'(beatLast), int'(lastExp));
      chk("R8 autopre", int'(beatAutoPre), int'(lastExp && ap));
      if (k != n - 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", int'(beatValid), 0);
    chk("R1 last", int'(beatLast), 0);
    chk("R1 autopre", int'(beatAutoPre), 0);
    rstN = 1'b1;
    @(negedge clk);

    // Sweep: every start column, every code, both orders (R2..R4, R6..R8, R11)
    for (int ilvI = 0; ilvI < 2; ilvI++) begin
      for (int code = 0; code < 8; code++) begin
        if (code == 7 && ilvI == 0) continue;
        for (int s = 0; s < 256; s++) begin
          bit ap;
          string req;
          ap = s[0] ^ s[3];
          req = (code > 3) ? "R6" : (ilvI != 0 ? "R4" : "R3");
          issue(s, code, bit'(ilvI), ap, s + code);
          checkBeats(req, s, code, bit'(ilvI), ap, burstLen(code, bit'(ilvI)));
          @(negedge clk);
          chk("R7 idle after last", int'(beatValid), 0);
        end
      end
    end

    // Full page, wrap 255 -> 0, no last, then terminate (R5, R9)
    for (int s = 240; s < 256; s += 5) begin
      issue(s, 7, 1'b0, 1'b1, 3);
      checkBeats("R5", s, 7, 1'b0, 1'b1, 300);
      cmdStop = 1'b1;
      @(negedge clk);
      cmdStop = 1'b0;
      chk("R9 stop full page", int'(beatValid), 0);
      chk("R9 no last", int'(beatLast), 0);
    end

    // Terminate mid-burst of 8 (R9)
    for (int s = 0; s < 256; s += 17) begin
      issue(s, 3, s[1], 1'b1, 0);
      checkBeats("R9 pre", s, 3, s[1], 1'b1, 3);
      cmdStop = 1'b1;
      @(negedge clk);
      cmdStop = 1'b0;
      chk("R9 stop", int'(beatValid), 0);
      chk("R9 no autopre", int'(beatAutoPre), 0);
      @(negedge clk);
      chk("R9 stays idle", int'(beatValid), 0);
    end

    // Restart mid-burst, with and without simultaneous stop (R10)
    for (int s = 0; s < 256; s += 13) begin
      int s2;
      s2 = (s * 7 + 90) & 255;
      issue(s, 7, 1'b0, 1'b0, 1);
      checkBeats("R10 first", s, 7, 1'b0, 1'b0, 4);
      cmdStop = s[0];
      issue(s2, 2, 1'b1, 1'b1, 2);
      cmdStop = 1'b0;
      checkBeats("R10 restart", s2, 2, 1'b1, 1'b1, 4);
      @(negedge clk);
      chk("R10 end", int'(beatValid), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    wait (cycles >= 190000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule